// File: doc/BRIEF.md
# Multi-Queue Read Address Selector

This block sits on the read side of a multi-queue FIFO array that may be cascaded with up to seven identical neighbours. It watches one 8-bit read address bus that carries two kinds of request. With the queue strobe high it picks the queue to read. With the status strobe high it picks the status word that goes onto a flag bus. Only the device whose strapped ID equals the top three address bits acts on a request.

A queue change follows a fixed fall-through timing. On the selecting edge the read port still presents the old queue. One edge later the block asks the array to load the new queue's head word. On the second edge the new queue becomes the presented queue. Read enable plays no part in this timing. Queue requests are refused until the programming-busy indication has dropped. If both strobes arrive together, the block drops both requests and raises a protocol error. The read-data drive enable is formed from the three active-low controls and from the device's own selection state.

The controller uses five named states. `S_UNPROG` is the reset state and refuses queue requests. `S_IDLE` means programmed, with no queue yet. `S_SWITCH` is the first edge after a request. `S_FALL` is the head-word load. `S_ACTIVE` means a queue is presented. The transitions are:
- UNPROG→IDLE when busy is low.
- IDLE/ACTIVE→SWITCH on a matching queue request.
- SWITCH→SWITCH or FALL→SWITCH on a further matching request (restart).
- SWITCH→FALL otherwise.
- FALL→ACTIVE otherwise, which commits the queue.

Top module: `mq_rd_selector`

## Requirements
- R1: After reset, rd_q_vld, head_load, dout_oe, stat_word_vld and proto_err are all 0.
- R2: While the block has not yet seen prog_busy low on a clock edge, queue requests are ignored: rd_q_vld and head_load stay 0.
- R3: A matching queue request (qsel_stb=1, stat_stb=0, rd_addr[7:5]==dev_id) on edge E0 leaves rd_q unchanged after E0 and E1. After E2, rd_q equals rd_addr[4:0] sampled at E0 and rd_q_vld is 1.
- R4: head_load is 1 exactly in the cycle between E1 and E2 of a queue change, whatever rd_en_n is.
- R5: A queue request whose rd_addr[7:5] differs from dev_id leaves rd_q unchanged and deselects the device, so dout_oe is 0 until a matching queue request.
- R6: A matching status request (stat_stb=1, qsel_stb=0) sets stat_word to rd_addr[3:0] and pulses stat_word_vld for one cycle after the edge. rd_addr[4] is ignored. A non-matching status request produces no pulse.
- R7: If qsel_stb and stat_stb are both 1 on an edge, proto_err is 1 for the following cycle, no status pulse occurs, and the queue selection is unchanged.
- R8: dout_oe is 1 only when rd_en_n, out_en_n and chip_sel_n are all 0, the device is selected and rd_q_vld is 1.
- R9: A further matching queue request during a change restarts the latency. The latest address appears two edges after the last request, and the earlier one is never presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset |
| dev_id | input | 3 | Strapped device ID within the cascade |
| prog_busy | input | 1 | High while programming is still in progress |
| qsel_stb | input | 1 | Queue-address strobe |
| stat_stb | input | 1 | Status-word strobe |
| rd_addr | input | 8 | Shared address: [7:5] device, [4:0] queue or [3:0] status word |
| rd_en_n | input | 1 | Read enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| chip_sel_n | input | 1 | Chip select, active low |
| rd_q | output | 5 | Queue currently presented on the read port |
| rd_q_vld | output | 1 | A queue has been presented since reset |
| head_load | output | 1 | Load the head word of the new queue (fall-through) |
| dout_oe | output | 1 | Read-data drive enable |
| stat_word | output | 4 | Selected status word index |
| stat_word_vld | output | 1 | One-cycle pulse on a new status selection |
| proto_err | output | 1 | Both strobes were high on the previous edge |

## Verification
A queue request and a status request can land on the same edge. The bench provokes this with a directed collision and with random cycles in which each strobe is raised on its own. It judges the result by checking that proto_err pulses, that no status pulse appears, and that the presented queue does not move over the following edges. A queue change also overlaps read enables and new requests. Random stimulus therefore puts strobes inside the two-edge window, and each cycle is compared against the bench's model of the restart rule.

// File: rtl/mq_rd_pkg.sv
package mq_rd_pkg;
    typedef enum logic [2:0] {
        S_UNPROG = 3'd0,
        S_IDLE   = 3'd1,
        S_SWITCH = 3'd2,
        S_FALL   = 3'd3,
        S_ACTIVE = 3'd4
    } rd_state_t;
endpackage

// File: rtl/mq_addr_decode.sv
module mq_addr_decode #(
    parameter int QSEL_W = 5,
    parameter int DEV_W  = 3,
    parameter int STAT_W = 4,
    localparam int ADDR_W = QSEL_W + DEV_W
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DEV_W-1:0]  dev_id,
    input  logic              qsel_stb,
    input  logic              stat_stb,
    output logic              q_hit,
    output logic              q_miss,
    output logic              s_hit,
    output logic              clash,
    output logic [QSEL_W-1:0] q_field,
    output logic [STAT_W-1:0] s_field
);
    logic id_match;

    always_comb begin
        id_match = (rd_addr[ADDR_W-1 -: DEV_W] == dev_id);
        clash    = qsel_stb && stat_stb;
        q_hit    = qsel_stb && !stat_stb && id_match;
        q_miss   = qsel_stb && !stat_stb && !id_match;
        s_hit    = stat_stb && !qsel_stb && id_match;
        q_field  = rd_addr[QSEL_W-1:0];
        s_field  = rd_addr[STAT_W-1:0];
    end
endmodule

// File: rtl/mq_sel_fsm.sv
module mq_sel_fsm
    import mq_rd_pkg::*;
#(
    parameter int QSEL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_busy,
    input  logic              q_hit,
    input  logic              q_miss,
    input  logic [QSEL_W-1:0] q_field,
    output logic [QSEL_W-1:0] rd_q,
    output logic              rd_q_vld,
    output logic              head_load,
    output logic              dev_sel
);
    rd_state_t         state_q, state_d;
    logic [QSEL_W-1:0] pend_q;
    logic              commit;
    logic              programmed;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_UNPROG: if (!prog_busy) state_d = S_IDLE;
            S_IDLE:   if (q_hit) state_d = S_SWITCH;
            S_SWITCH: state_d = q_hit ? S_SWITCH : S_FALL;
            S_FALL:   state_d = q_hit ? S_SWITCH : S_ACTIVE;
            S_ACTIVE: if (q_hit) state_d = S_SWITCH;
            default:  state_d = S_UNPROG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_UNPROG;
        else        state_q <= state_d;
    end

    always_comb begin
        head_load  = (state_q == S_FALL);
        programmed = (state_q != S_UNPROG);
        commit     = (state_q == S_FALL) && !q_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= '0;
            rd_q     <= '0;
            rd_q_vld <= 1'b0;
            dev_sel  <= 1'b0;
        end else begin
            if (programmed && q_hit) pend_q <= q_field;
            if (commit) begin
                rd_q     <= pend_q;
                rd_q_vld <= 1'b1;
            end
            if (programmed && q_hit)       dev_sel <= 1'b1;
            else if (programmed && q_miss) dev_sel <= 1'b0;
        end
    end
endmodule

// File: rtl/mq_stat_reg.sv
module mq_stat_reg #(
    parameter int STAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_hit,
    input  logic              clash,
    input  logic [STAT_W-1:0] s_field,
    output logic [STAT_W-1:0] stat_word,
    output logic              stat_word_vld,
    output logic              proto_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_word     <= '0;
            stat_word_vld <= 1'b0;
            proto_err     <= 1'b0;
        end else begin
            stat_word_vld <= s_hit;
            proto_err     <= clash;
            if (s_hit) stat_word <= s_field;
        end
    end
endmodule

// File: rtl/mq_rd_selector.sv
module mq_rd_selector #(
    parameter int QSEL_W = 5,
    parameter int DEV_W  = 3,
    parameter int STAT_W = 4,
    localparam int ADDR_W = QSEL_W + DEV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  dev_id,
    input  logic              prog_busy,
    input  logic              qsel_stb,
    input  logic              stat_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_en_n,
    input  logic              out_en_n,
    input  logic              chip_sel_n,
    output logic [QSEL_W-1:0] rd_q,
    output logic              rd_q_vld,
    output logic              head_load,
    output logic              dout_oe,
    output logic [STAT_W-1:0] stat_word,
    output logic              stat_word_vld,
    output logic              proto_err
);
    logic              q_hit, q_miss, s_hit, clash, dev_sel;
    logic [QSEL_W-1:0] q_field;
    logic [STAT_W-1:0] s_field;

    mq_addr_decode #(.QSEL_W(QSEL_W), .DEV_W(DEV_W), .STAT_W(STAT_W)) dec_i (
        .rd_addr (rd_addr),
        .dev_id  (dev_id),
        .qsel_stb(qsel_stb),
        .stat_stb(stat_stb),
        .q_hit   (q_hit),
        .q_miss  (q_miss),
        .s_hit   (s_hit),
        .clash   (clash),
        .q_field (q_field),
        .s_field (s_field)
    );

    mq_sel_fsm #(.QSEL_W(QSEL_W)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_busy(prog_busy),
        .q_hit    (q_hit),
        .q_miss   (q_miss),
        .q_field  (q_field),
        .rd_q     (rd_q),
        .rd_q_vld (rd_q_vld),
        .head_load(head_load),
        .dev_sel  (dev_sel)
    );

    mq_stat_reg #(.STAT_W(STAT_W)) stat_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .s_hit        (s_hit),
        .clash        (clash),
        .s_field      (s_field),
        .stat_word    (stat_word),
        .stat_word_vld(stat_word_vld),
        .proto_err    (proto_err)
    );

    always_comb begin
        dout_oe = !rd_en_n && !out_en_n && !chip_sel_n && dev_sel && rd_q_vld;
    end
endmodule

// File: rtl/mq_rd_selector_chk.sv
module mq_rd_selector_chk #(
    parameter int QSEL_W = 5,
    parameter int STAT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              qsel_stb,
    input logic              stat_stb,
    input logic              rd_en_n,
    input logic              out_en_n,
    input logic              chip_sel_n,
    input logic [QSEL_W-1:0] rd_q,
    input logic              rd_q_vld,
    input logic              head_load,
    input logic              dout_oe,
    input logic [STAT_W-1:0] stat_word,
    input logic              stat_word_vld,
    input logic              proto_err
);
    // R7
    clash_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qsel_stb && stat_stb) |=> proto_err);

    // R7
    clash_no_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qsel_stb && stat_stb) |=> !stat_word_vld);

    // R8
    oe_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!rd_en_n && !out_en_n && !chip_sel_n && rd_q_vld));

    // R4
    load_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_load && !qsel_stb) |=> rd_q_vld);

    // R6
    stat_from_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word_vld |-> $past(stat_stb && !qsel_stb));

    // R3
    valid_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_q_vld) |-> $past(head_load));
endmodule

bind mq_rd_selector mq_rd_selector_chk #(.QSEL_W(QSEL_W), .STAT_W(STAT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .qsel_stb     (qsel_stb),
    .stat_stb     (stat_stb),
    .rd_en_n      (rd_en_n),
    .out_en_n     (out_en_n),
    .chip_sel_n   (chip_sel_n),
    .rd_q         (rd_q),
    .rd_q_vld     (rd_q_vld),
    .head_load    (head_load),
    .dout_oe      (dout_oe),
    .stat_word    (stat_word),
    .stat_word_vld(stat_word_vld),
    .proto_err    (proto_err)
);

// File: tb/mq_rd_selector_tb_top.sv
module mq_rd_selector_tb_top;
    localparam logic [2:0] MY_ID = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] dev_id = MY_ID;
    logic       prog_busy = 1'b1;
    logic       qsel_stb = 1'b0;
    logic       stat_stb = 1'b0;
    logic [7:0] rd_addr = '0;
    logic       rd_en_n = 1'b1;
    logic       out_en_n = 1'b1;
    logic       chip_sel_n = 1'b1;
    logic [4:0] rd_q;
    logic       rd_q_vld, head_load, dout_oe, stat_word_vld, proto_err;
    logic [3:0] stat_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    bit         m_unprog = 1;
    int         m_cnt = 0;
    logic [4:0] m_pend = '0;
    logic [4:0] m_q = '0;
    bit         m_qv = 0;
    bit         m_sel = 0;
    logic [3:0] m_stat = '0;
    bit         m_statv = 0;
    bit         m_err = 0;

    always #2.5 clk = ~clk;

    mq_rd_selector dut_i (
        .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .prog_busy(prog_busy),
        .qsel_stb(qsel_stb), .stat_stb(stat_stb), .rd_addr(rd_addr),
        .rd_en_n(rd_en_n), .out_en_n(out_en_n), .chip_sel_n(chip_sel_n),
        .rd_q(rd_q), .rd_q_vld(rd_q_vld), .head_load(head_load),
        .dout_oe(dout_oe), .stat_word(stat_word),
        .stat_word_vld(stat_word_vld), .proto_err(proto_err)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit id_hit(logic [7:0] a);
        return a[7:5] == MY_ID;
    endfunction

    function automatic bit exp_oe();
        return !rd_en_n && !out_en_n && !chip_sel_n && m_sel && m_qv;
    endfunction

    task automatic model_step();
        bit both;
        both = qsel_stb && stat_stb;
        m_err = both;
        m_statv = stat_stb && !qsel_stb && id_hit(rd_addr);
        if (m_statv) m_stat = rd_addr[3:0];
        if (m_unprog) begin
            if (!prog_busy) m_unprog = 0;
        end else begin
            if (qsel_stb && !both && id_hit(rd_addr)) begin
                m_pend = rd_addr[4:0];
                m_cnt = 2;
                m_sel = 1;
            end else begin
                if (m_cnt == 1) begin
                    m_q = m_pend;
                    m_qv = 1;
                    m_cnt = 0;
                end else if (m_cnt == 2) begin
                    m_cnt = 1;
                end
                if (qsel_stb && !both) m_sel = 0;
            end
        end
    endtask

    task automatic compare_all();
        chk("R3 rd_q_vld", rd_q_vld, m_qv);
        if (m_qv) chk("R3 rd_q", rd_q, m_q);
        chk("R4 head_load", head_load, m_cnt == 1);
        chk("R8 dout_oe", dout_oe, exp_oe());
        chk("R6 stat_word_vld", stat_word_vld, m_statv);
        if (m_statv) chk("R6 stat_word", stat_word, m_stat);
        chk("R7 proto_err", proto_err, m_err);
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_in();
        qsel_stb = 0;
        stat_stb = 0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rd_q_vld", rd_q_vld, 0);
        chk("R1 head_load", head_load, 0);
        chk("R1 dout_oe", dout_oe, 0);
        chk("R1 stat_word_vld", stat_word_vld, 0);
        chk("R1 proto_err", proto_err, 0);
        rst_n = 1;

        // R2 queue request while programming busy
        qsel_stb = 1;
        rd_addr = {MY_ID, 5'd3};
        repeat (3) begin
            cycle();
            chk("R2 rd_q_vld", rd_q_vld, 0);
            chk("R2 head_load", head_load, 0);
        end
        idle_in();
        cycle();
        chk("R2 rd_q_vld after", rd_q_vld, 0);
        prog_busy = 0;
        cycle();

        // R3 / R4 latency, read enable held inactive
        rd_en_n = 1;
        qsel_stb = 1;
        rd_addr = {MY_ID, 5'd9};
        cycle();
        idle_in();
        chk("R3 old after E0", rd_q_vld, 0);
        cycle();
        chk("R4 load after E1", head_load, 1);
        chk("R3 old after E1", rd_q_vld, 0);
        cycle();
        chk("R3 new after E2", rd_q, 9);
        chk("R4 load off after E2", head_load, 0);

        // R8 drive enable
        rd_en_n = 0; out_en_n = 0; chip_sel_n = 0;
        cycle();
        chk("R8 all active", dout_oe, 1);
        chip_sel_n = 1;
        cycle();
        chk("R8 chip sel off", dout_oe, 0);
        chip_sel_n = 0;

        // R5 other device selected
        qsel_stb = 1;
        rd_addr = {3'd2, 5'd20};
        cycle();
        idle_in();
        repeat (3) cycle();
        chk("R5 rd_q kept", rd_q, 9);
        chk("R5 dout_oe off", dout_oe, 0);

        // R6 status select with bit 4 set, then mismatch
        stat_stb = 1;
        rd_addr = {MY_ID, 1'b1, 4'hA};
        cycle();
        chk("R6 stat word", stat_word, 4'hA);
        chk("R6 stat pulse", stat_word_vld, 1);
        idle_in();
        cycle();
        chk("R6 pulse one cycle", stat_word_vld, 0);
        stat_stb = 1;
        rd_addr = {3'd1, 1'b0, 4'h3};
        cycle();
        idle_in();
        chk("R6 mismatch no pulse", stat_word_vld, 0);

        // R7 both strobes
        qsel_stb = 1; stat_stb = 1;
        rd_addr = {MY_ID, 5'd17};
        cycle();
        idle_in();
        chk("R7 error pulse", proto_err, 1);
        chk("R7 no status", stat_word_vld, 0);
        repeat (3) cycle();
        chk("R7 queue kept", rd_q, 9);
        chk("R7 no load", head_load, 0);

        // R9 restart during change
        qsel_stb = 1;
        rd_addr = {MY_ID, 5'd3};
        cycle();
        rd_addr = {MY_ID, 5'd12};
        cycle();
        idle_in();
        chk("R9 old kept", rd_q, 9);
        cycle();
        chk("R9 still old", rd_q, 9);
        cycle();
        chk("R9 latest wins", rd_q, 12);

        // random phase
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 3000; i++) begin
            qsel_stb   = ($urandom % 6) == 0;
            stat_stb   = ($urandom % 6) == 0;
            rd_addr    = 8'($urandom);
            if ($urandom % 2) rd_addr[7:5] = MY_ID;
            rd_en_n    = ($urandom % 3) == 0;
            out_en_n   = ($urandom % 5) == 0;
            chip_sel_n = ($urandom % 5) == 0;
            cycle();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule